// File: doc/BRIEF.md
# SIMD Signed-Saturating Pack Unit

This block narrows the signed elements of two source vectors to half their width and clamps every value that does not fit into the narrower signed range. It has two element modes: 16-bit elements become 8-bit elements, or 32-bit elements become 16-bit elements. The result is built one 128-bit lane at a time. In each lane, the narrowed elements of source one fill the lower 64 bits and the narrowed elements of source two fill the upper 64 bits. Data never crosses from one lane to another.

Each narrowed element can be written, left at its previous destination value (merge), or cleared (zeroing), as selected by a per-element write mask. In 32-bit mode, the low 32 bits of source two can be broadcast to every 32-bit slot of source two. Bits above the selected vector length are cleared. A legacy 128-bit form is also available: it uses the previous destination as source one and leaves the destination bits above 127 untouched.

The result is computed combinationally and captured in one output register. A two-state control machine raises out_valid in the cycle after a request. The machine states are ST_IDLE, in which no fresh result is held, and ST_LOADED, in which the register holds the result of the previous cycle's request. Every state moves to ST_LOADED when in_valid is high and to ST_IDLE when it is low. A synchronous reset forces ST_IDLE.

Top module: `sat_pack_unit`

## Requirements
- R1: In byte mode (mode_dw=0), a signed 16-bit input greater than 127 yields 0x7F. An input less than -128 yields 0x80. Any other input yields its low 8 bits.
- R2: In word mode (mode_dw=1), a signed 32-bit input greater than 32767 yields 0x7FFF. An input less than -32768 yields 0x8000. Any other input yields its low 16 bits.
- R3: Inside 128-bit lane L, result bits L*128+63:L*128 hold the narrowed elements of source one's lane L in ascending order. Bits L*128+127:L*128+64 hold the narrowed elements of source two's lane L in the same order.
- R4: vlen_sel selects the vector length: 0 selects 128 bits, 1 selects 256 bits, and 2 or 3 selects 512 bits. Only mask bits below 16/32/64 (byte mode) or 8/16/32 (word mode) are used.
- R5: When mask_en=1 and zero_mask=0, an element whose mask bit is 0 keeps its value from prev_dst.
- R6: When mask_en=1 and zero_mask=1, an element whose mask bit is 0 becomes zero.
- R7: When mask_en=0, every element below the vector length is written, whatever the value of wmask.
- R8: In word mode, bcast=1 replaces every 32-bit slot of source two with src_b[31:0] before narrowing. In byte mode, bcast has no effect.
- R9: In the non-legacy forms (legacy=0), all result bits at or above the vector length are zero.
- R10: When legacy=1, source one is prev_dst and the vector length is 128. Result bits 511:128 equal prev_dst[511:128]. The inputs src_a, wmask, mask_en and bcast are ignored.
- R11: out_valid is 1 exactly in the cycle after in_valid was sampled high. The result register loads only on in_valid and otherwise holds. A synchronous reset (rst=1) clears both out_valid and the result.
- R12: Mask bit j governs element j of the final packed layout, that is, bits j*8+7:j*8 in byte mode or j*16+15:j*16 in word mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe; all operands are sampled with it |
| mode_dw | input | 1 | 0: 16-to-8 narrowing, 1: 32-to-16 narrowing |
| vlen_sel | input | 2 | Vector length: 0=128, 1=256, 2/3=512 |
| mask_en | input | 1 | Enables the per-element write mask |
| zero_mask | input | 1 | 1: masked-off elements are cleared; 0: they merge |
| bcast | input | 1 | Broadcast src_b[31:0] over source two (word mode) |
| legacy | input | 1 | Legacy 128-bit form |
| src_a | input | 512 | Source one |
| src_b | input | 512 | Source two |
| prev_dst | input | 512 | Previous destination value |
| wmask | input | 64 | Per-element write mask |
| out_valid | output | 1 | Result holds a fresh value |
| result | output | 512 | Registered packed result |

## Verification
If the control machine is stuck in either state, the valid flag is wrong in the very next cycle: it either misses a request or reports a stale result as fresh. A wrong lane or mask decision shows up as a corrupt element in the registered result one cycle after the request. Directed saturation boundaries and random operands in every mode combination expose such corruption as soon as the following cycle. A failure to clear the upper bits, or to hold them in the legacy form, is seen on the first request in that form.

// File: rtl/sat_pack_pkg.sv
package sat_pack_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_LOADED = 1'b1
    } pack_state_e;

    // 16-bit signed value clamped into 8-bit signed range
    function automatic logic [7:0] clamp_w2b(input logic [15:0] v);
        logic [7:0] r;
        if ($signed(v) > 16'sd127)
            r = 8'h7F;
        else if ($signed(v) < -16'sd128)
            r = 8'h80;
        else
            r = v[7:0];
        return r;
    endfunction

    // 32-bit signed value clamped into 16-bit signed range
    function automatic logic [15:0] clamp_d2w(input logic [31:0] v);
        logic [15:0] r;
        if ($signed(v) > 32'sd32767)
            r = 16'h7FFF;
        else if ($signed(v) < -32'sd32768)
            r = 16'h8000;
        else
            r = v[15:0];
        return r;
    endfunction

endpackage

// File: rtl/sat_pack_lane.sv
module sat_pack_lane
    import sat_pack_pkg::*;
#(
    parameter int LANE_W = 128
) (
    input  logic              mode_dw,
    input  logic [LANE_W-1:0] s1,
    input  logic [LANE_W-1:0] s2,
    output logic [LANE_W-1:0] packed_o
);
    localparam int HALF_W = LANE_W / 2;
    localparam int N_W    = LANE_W / 16;  // 16-bit inputs per source lane
    localparam int N_D    = LANE_W / 32;  // 32-bit inputs per source lane

    logic [LANE_W-1:0] by_bytes;
    logic [LANE_W-1:0] by_words;

    genvar k;
    generate
        for (k = 0; k < N_W; k++) begin : g_w2b
            assign by_bytes[k*8 +: 8]          = clamp_w2b(s1[k*16 +: 16]);
            assign by_bytes[HALF_W + k*8 +: 8] = clamp_w2b(s2[k*16 +: 16]);
        end
        for (k = 0; k < N_D; k++) begin : g_d2w
            assign by_words[k*16 +: 16]          = clamp_d2w(s1[k*32 +: 32]);
            assign by_words[HALF_W + k*16 +: 16] = clamp_d2w(s2[k*32 +: 32]);
        end
    endgenerate

    assign packed_o = mode_dw ? by_words : by_bytes;
endmodule

// File: rtl/sat_pack_mask.sv
module sat_pack_mask #(
    parameter int VEC_W  = 512,
    parameter int LANE_W = 128
) (
    input  logic               mode_dw,
    input  logic               legacy,
    input  logic               mask_en,
    input  logic               zero_mask,
    input  logic [1:0]         vlen_sel,
    input  logic [VEC_W/8-1:0] wmask,
    input  logic [VEC_W-1:0]   packed_i,
    input  logic [VEC_W-1:0]   prev,
    output logic [VEC_W-1:0]   res
);
    localparam int N_BYTES    = VEC_W / 8;
    localparam int LANE_BYTES = LANE_W / 8;
    localparam int LANES      = VEC_W / LANE_W;
    localparam int LW         = $clog2(LANES + 1);

    logic [LW-1:0] lanes_used;

    always_comb begin
        if (legacy || vlen_sel == 2'd0)
            lanes_used = LW'(1);
        else if (vlen_sel == 2'd1)
            lanes_used = LW'(2);
        else
            lanes_used = LW'(LANES);
    end

    genvar b;
    generate
        for (b = 0; b < N_BYTES; b++) begin : g_byte
            localparam int LANE_IDX = b / LANE_BYTES;
            logic mbit;
            logic in_range;
            assign mbit     = mode_dw ? wmask[b/2] : wmask[b];
            assign in_range = (LW'(LANE_IDX) < lanes_used);
            always_comb begin
                if (legacy)
                    res[b*8 +: 8] = in_range ? packed_i[b*8 +: 8] : prev[b*8 +: 8];
                else if (!in_range)
                    res[b*8 +: 8] = 8'h00;
                else if (!mask_en || mbit)
                    res[b*8 +: 8] = packed_i[b*8 +: 8];
                else if (zero_mask)
                    res[b*8 +: 8] = 8'h00;
                else
                    res[b*8 +: 8] = prev[b*8 +: 8];
            end
        end
    endgenerate
endmodule

// File: rtl/sat_pack_unit.sv
module sat_pack_unit
    import sat_pack_pkg::*;
#(
    parameter int VEC_W  = 512,
    parameter int LANE_W = 128
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               mode_dw,
    input  logic [1:0]         vlen_sel,
    input  logic               mask_en,
    input  logic               zero_mask,
    input  logic               bcast,
    input  logic               legacy,
    input  logic [VEC_W-1:0]   src_a,
    input  logic [VEC_W-1:0]   src_b,
    input  logic [VEC_W-1:0]   prev_dst,
    input  logic [VEC_W/8-1:0] wmask,
    output logic               out_valid,
    output logic [VEC_W-1:0]   result
);
    localparam int LANES  = VEC_W / LANE_W;
    localparam int N_SLOT = VEC_W / 32;

    pack_state_e        state_q, state_d;
    logic [VEC_W-1:0]   s1_eff, s2_eff, packed_all, next_res;
    logic               bc_eff;

    assign bc_eff = bcast && mode_dw && !legacy;
    assign s1_eff = legacy ? prev_dst : src_a;
    assign s2_eff = bc_eff ? {N_SLOT{src_b[31:0]}} : src_b;

    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_lane
            sat_pack_lane #(.LANE_W(LANE_W)) u_lane (
                .mode_dw  (mode_dw),
                .s1       (s1_eff[l*LANE_W +: LANE_W]),
                .s2       (s2_eff[l*LANE_W +: LANE_W]),
                .packed_o (packed_all[l*LANE_W +: LANE_W])
            );
        end
    endgenerate

    sat_pack_mask #(.VEC_W(VEC_W), .LANE_W(LANE_W)) u_mask (
        .mode_dw   (mode_dw),
        .legacy    (legacy),
        .mask_en   (mask_en && !legacy),
        .zero_mask (zero_mask),
        .vlen_sel  (vlen_sel),
        .wmask     (wmask),
        .packed_i  (packed_all),
        .prev      (prev_dst),
        .res       (next_res)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_LOADED : ST_IDLE;
            ST_LOADED: state_d = in_valid ? ST_LOADED : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst)
            result <= '0;
        else if (in_valid)
            result <= next_res;
    end

    assign out_valid = (state_q == ST_LOADED);
endmodule

// File: rtl/sat_pack_unit_chk.sv
module sat_pack_unit_chk #(
    parameter int VEC_W = 512
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               mode_dw,
    input logic [1:0]         vlen_sel,
    input logic               mask_en,
    input logic               zero_mask,
    input logic               legacy,
    input logic [VEC_W-1:0]   src_a,
    input logic [VEC_W-1:0]   prev_dst,
    input logic [VEC_W/8-1:0] wmask,
    input logic               out_valid,
    input logic [VEC_W-1:0]   result
);
    a_r11_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));

    a_r11_valid_next: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r11_idle_next: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));

    a_r9_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !legacy && vlen_sel == 2'd0) |=> (result[VEC_W-1:128] == '0));

    a_r10_upper_kept: assert property (@(posedge clk) disable iff (rst)
        (in_valid && legacy) |=> (result[VEC_W-1:128] == $past(prev_dst[VEC_W-1:128])));

    a_r5_merge_elem0: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !legacy && !mode_dw && mask_en && !zero_mask && !wmask[0])
        |=> (result[7:0] == $past(prev_dst[7:0])));

    a_r6_zero_elem0: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !legacy && mode_dw && mask_en && zero_mask && !wmask[0])
        |=> (result[15:0] == 16'h0000));

    a_r1_clamp_high: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !legacy && !mode_dw && !mask_en && ($signed(src_a[15:0]) > 16'sd127))
        |=> (result[7:0] == 8'h7F));
endmodule

bind sat_pack_unit sat_pack_unit_chk #(.VEC_W(VEC_W)) chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode_dw(mode_dw),
    .vlen_sel(vlen_sel), .mask_en(mask_en), .zero_mask(zero_mask),
    .legacy(legacy), .src_a(src_a), .prev_dst(prev_dst), .wmask(wmask),
    .out_valid(out_valid), .result(result)
);

// File: tb/sat_pack_unit_test.sv
`timescale 1ns/1ps
module sat_pack_unit_test;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         mode_dw;
    logic [1:0]   vlen_sel;
    logic         mask_en, zero_mask, bcast, legacy;
    logic [511:0] src_a, src_b, prev_dst;
    logic [63:0]  wmask;
    logic         out_valid;
    logic [511:0] result;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sat_pack_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode_dw(mode_dw),
        .vlen_sel(vlen_sel), .mask_en(mask_en), .zero_mask(zero_mask),
        .bcast(bcast), .legacy(legacy), .src_a(src_a), .src_b(src_b),
        .prev_dst(prev_dst), .wmask(wmask), .out_valid(out_valid), .result(result)
    );

    function automatic logic [7:0] ref_b(input logic [15:0] x);
        int v = int'($signed(x));
        if (v > 127) return 8'h7F;
        if (v < -128) return 8'h80;
        return x[7:0];
    endfunction

    function automatic logic [15:0] ref_w(input logic [31:0] x);
        longint v = longint'($signed(x));
        if (v > 32767) return 16'h7FFF;
        if (v < -32768) return 16'h8000;
        return x[15:0];
    endfunction

    // Expected result built element by element of the output layout
    function automatic logic [511:0] model();
        logic [511:0] s1, s2, r;
        int nl;
        s1 = legacy ? prev_dst : src_a;
        s2 = src_b;
        if (mode_dw && bcast && !legacy)
            for (int i = 0; i < 16; i++) s2[i*32 +: 32] = src_b[31:0];
        nl = legacy ? 1 : (vlen_sel == 2'd0 ? 1 : (vlen_sel == 2'd1 ? 2 : 4));
        r = '0;
        if (mode_dw) begin
            for (int e = 0; e < 32; e++) begin
                int ln = e / 8;
                int k  = e % 8;
                logic [31:0] x = (k < 4) ? s1[(ln*4 + k)*32 +: 32] : s2[(ln*4 + k - 4)*32 +: 32];
                logic [15:0] v = ref_w(x);
                if (legacy) r[e*16 +: 16] = (ln == 0) ? v : prev_dst[e*16 +: 16];
                else if (ln >= nl) r[e*16 +: 16] = 16'h0;
                else if (!mask_en || wmask[e]) r[e*16 +: 16] = v;
                else r[e*16 +: 16] = zero_mask ? 16'h0 : prev_dst[e*16 +: 16];
            end
        end else begin
            for (int e = 0; e < 64; e++) begin
                int ln = e / 16;
                int k  = e % 16;
                logic [15:0] x = (k < 8) ? s1[(ln*8 + k)*16 +: 16] : s2[(ln*8 + k - 8)*16 +: 16];
                logic [7:0] v = ref_b(x);
                if (legacy) r[e*8 +: 8] = (ln == 0) ? v : prev_dst[e*8 +: 8];
                else if (ln >= nl) r[e*8 +: 8] = 8'h0;
                else if (!mask_en || wmask[e]) r[e*8 +: 8] = v;
                else r[e*8 +: 8] = zero_mask ? 8'h0 : prev_dst[e*8 +: 8];
            end
        end
        return r;
    endfunction

    function automatic logic [511:0] rnd512();
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic check512(input string tag, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Drive one request at a negedge, check at the negedge after capture
    task automatic run_case(input string tag);
        logic [511:0] exp = model();
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check1({tag, " valid"}, out_valid, 1'b1);
        check512(tag, result, exp);
    endtask

    task automatic defaults();
        mode_dw = 0; vlen_sel = 2'd2; mask_en = 0; zero_mask = 0;
        bcast = 0; legacy = 0; wmask = '0;
        src_a = rnd512(); src_b = rnd512(); prev_dst = rnd512();
    endtask

    initial begin
        void'($urandom(32'd7741));
        rst = 1'b1; in_valid = 1'b0;
        defaults();
        repeat (3) @(negedge clk);
        check1("R11 reset valid", out_valid, 1'b0);
        check512("R11 reset result", result, '0);
        rst = 1'b0;
        @(negedge clk);

        // R1 directed clamp boundaries
        defaults();
        src_a[127:0] = {16'hFFFF, 16'h0000, 16'hFF80, 16'h007F, 16'hFF7F, 16'h0080, 16'h8000, 16'h7FFF};
        run_case("R1 byte clamp");
        check512("R1 byte low lane", {448'h0, result[63:0]}, {448'h0, 64'hFF00807F807F807F});

        // R2 directed clamp boundaries
        defaults(); mode_dw = 1;
        src_a[127:0] = {32'hFFFF8000, 32'h00007FFF, 32'hFFFF7FFF, 32'h00008000};
        run_case("R2 word clamp");
        check512("R2 word low lane", {448'h0, result[63:0]}, {448'h0, 64'h80007FFF80007FFF});

        // R3 lane placement, small in-range values
        defaults();
        for (int i = 0; i < 32; i++) begin
            src_a[i*16 +: 16] = 16'(i);
            src_b[i*16 +: 16] = 16'(i + 64);
        end
        run_case("R3 lanes");
        check512("R3 lane1 low half", {448'h0, result[191:128]}, {448'h0, 64'h0F0E0D0C0B0A0908});

        // R4 / R9 vector length 256, upper zero
        defaults(); vlen_sel = 2'd1; mode_dw = 1;
        run_case("R4 vlen256");
        check512("R9 upper zero", {256'h0, result[511:256]}, '0);
        defaults(); vlen_sel = 2'd3;
        run_case("R4 vlen sel3 is 512");

        // R5 merge, R6 zero, R7 mask off
        defaults(); mask_en = 1; zero_mask = 0; wmask = {$urandom, $urandom};
        run_case("R5 merge");
        defaults(); mask_en = 1; zero_mask = 1; mode_dw = 1; wmask = {$urandom, $urandom};
        run_case("R6 zeroing");
        defaults(); mask_en = 0; wmask = '0;
        run_case("R7 mask off");

        // R8 broadcast in both modes
        defaults(); mode_dw = 1; bcast = 1; src_b[31:0] = 32'h0001_2345;
        run_case("R8 bcast word");
        check512("R8 bcast hi half", {448'h0, result[127:64]}, {448'h0, 64'h7FFF7FFF7FFF7FFF});
        defaults(); mode_dw = 0; bcast = 1;
        run_case("R8 bcast ignored byte");

        // R10 legacy form
        defaults(); legacy = 1; mask_en = 1; zero_mask = 1; wmask = '0; bcast = 1; mode_dw = 1;
        run_case("R10 legacy");

        // R12 single mask bit in word mode
        defaults(); mode_dw = 1; mask_en = 1; zero_mask = 1; wmask = 64'h20;
        src_b = '0;
        run_case("R12 single bit");
        check512("R12 only element5", {416'h0, result[95:0]}, {416'h0, 96'h0});

        // R11 hold when idle
        begin
            logic [511:0] held = result;
            src_a = rnd512();
            @(negedge clk);
            check1("R11 idle valid", out_valid, 1'b0);
            check512("R11 hold", result, held);
        end

        // Random mix
        for (int n = 0; n < 400; n++) begin
            defaults();
            mode_dw = 1'($urandom); vlen_sel = 2'($urandom);
            mask_en = 1'($urandom); zero_mask = 1'($urandom);
            bcast = 1'($urandom); legacy = (($urandom % 5) == 0);
            wmask = {$urandom, $urandom};
            if ($urandom % 2) begin
                for (int i = 0; i < 32; i++)
                    src_a[i*16 +: 16] = 16'($signed(9'($urandom)));
            end
            run_case("R3/R12 random");
            if ($urandom % 4 == 0) @(negedge clk);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog R11 actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule